// File: doc/BRIEF.md
# Fractional USART Baud Rate Generator

This block produces the timing strobes a USART needs. It picks an input tick from one of three sources: the system clock, the system clock after a fixed prescaler, or a serial clock pin. The pin is synchronised into the system clock domain first. A 16-bit integer divisor and a 3-bit fractional part then divide that tick stream. All results are one-cycle enables in the system clock domain. The one exception is the serial clock output pin.

In asynchronous mode, the divider output is the receiver sampling strobe. Its average period is CD + FP/8 input ticks. The modulus stage gets this by stretching FP of every eight divider periods by one tick. The baud strobe fires once every 16 sampling strobes, or once every 8 when the oversampling bit is set.

In synchronous mode, the tick is divided by CD with no fraction, and the sampling strobe equals the baud strobe. The serial clock output runs at the baud period. On the system clock source it has a 50% duty cycle even for odd CD: a half-cycle extension is timed from the falling clock edge. When the pin is the source in synchronous mode, each synchronised rising edge is a baud strobe and the divisor is ignored.

Top module: `frac_baud_gen`

## Requirements
- R1: src_sel_i picks the input tick. Code 0 gives a tick on every system clock cycle. Code 1 gives one tick every PRESC_DIV cycles (default 8). Code 3 gives one tick per rising edge of ext_sck_i after a two-flop synchroniser.
- R2: With sync_mode_i=1 and source 0 or 1, baud_en_o pulses once every CD ticks. samp_en_o pulses in the same cycles as baud_en_o.
- R3: With sync_mode_i=1 and source 3, baud_en_o and samp_en_o pulse once per pin rising edge, whatever the value of cd_i, including 0. sck_o follows the synchronised pin level.
- R4: With sync_mode_i=0 and CD>=2, eight consecutive samp_en_o periods span exactly 8*CD+FP ticks. FP of those eight periods are CD+1 ticks long, and the rest are CD ticks.
- R5: With sync_mode_i=0, baud_en_o pulses on every 16th samp_en_o pulse when over_i=0, and on every 8th when over_i=1. Each baud_en_o pulse coincides with a samp_en_o pulse.
- R6: With sync_mode_i=0 and CD=1, fp_i has no effect, and samp_en_o pulses on every tick.
- R7: CD=0 stops baud_en_o, samp_en_o and sck_o, except for the pin source in synchronous mode.
- R8: Source code 2 is reserved. It produces no ticks, so all outputs stay low.
- R9: In synchronous mode with source 0 and CD>=2, sck_o is high for exactly CD half-cycles of the system clock in each CD-cycle period. This holds for odd CD as well.
- R10: In synchronous mode with source 1, sck_o is high for floor(CD/2) ticks in each period of CD ticks, so an odd CD gives an unbalanced duty cycle.
- R11: With sync_mode_i=0, sck_o stays low.
- R12: While rst_ni is low, baud_en_o, samp_en_o and sck_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_sck_i | input | 1 | External serial clock pin, asynchronous |
| src_sel_i | input | 2 | Tick source: 0 system, 1 prescaled, 2 reserved, 3 pin |
| sync_mode_i | input | 1 | 1 selects synchronous mode, 0 selects asynchronous mode |
| over_i | input | 1 | Asynchronous oversampling: 0 selects x16, 1 selects x8 |
| cd_i | input | 16 | Integer divisor |
| fp_i | input | 3 | Fractional part, in eighths |
| baud_en_o | output | 1 | One-cycle baud strobe |
| samp_en_o | output | 1 | One-cycle sampling strobe |
| sck_o | output | 1 | Serial clock output |

## Verification
Both strobes are registered one clock after the cycle in which the divider reaches its terminal count. A pin edge reaches the divider two clocks after the pin changes, through the synchroniser. sck_o settles on the clock edge that follows each counter update, and the odd-divisor extension ends at the next falling edge. The checks therefore never predict an absolute phase. Each configuration runs for a warm-up period, and the bench then counts pulses and sck_o high half-cycles over a window that is a whole number of output periods. The counts over such a window do not depend on phase or latency. sck_o is sampled a quarter period after each clock edge, which resolves half-cycle duty.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  typedef enum logic [1:0] {
    SRC_SYS = 2'd0,
    SRC_PRE = 2'd1,
    SRC_RSV = 2'd2,
    SRC_EXT = 2'd3
  } src_e;
endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel
  import frac_baud_pkg::*;
#(
  parameter int PRESC_DIV = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_sck_i,
  input  logic [1:0] src_sel_i,
  output logic       tick_o,
  output logic       ext_lvl_o
);
  localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;

  logic [PW-1:0] pcnt_q;
  logic          pre_tick_q;
  logic [2:0]    sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q     <= '0;
      pre_tick_q <= 1'b0;
    end else begin
      pre_tick_q <= (pcnt_q == PW'(PRESC_DIV - 1));
      pcnt_q     <= (pcnt_q == PW'(PRESC_DIV - 1)) ? '0 : pcnt_q + 1'b1;
    end
  end

  // two-flop synchroniser plus edge history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ext_sck_i};
  end

  assign ext_lvl_o = sync_q[1];

  always_comb begin
    unique case (src_e'(src_sel_i))
      SRC_SYS: tick_o = 1'b1;
      SRC_PRE: tick_o = pre_tick_q;
      SRC_EXT: tick_o = sync_q[1] & ~sync_q[2];
      default: tick_o = 1'b0;
    endcase
  end

  // R1
  presc_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tick_q |=> !pre_tick_q);
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int CD_W = 16,
  parameter int FP_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            bypass_i,
  input  logic            frac_en_i,
  input  logic [CD_W-1:0] cd_i,
  input  logic [FP_W-1:0] fp_i,
  output logic            term_o,
  output logic [CD_W-1:0] cnt_next_o
);
  localparam int PER_W = CD_W + 1;

  logic [CD_W-1:0] cnt_q;
  logic [FP_W-1:0] acc_q;
  logic            stretch_q;
  logic [PER_W-1:0] per;
  logic [FP_W:0]   sum;
  logic            stop;

  assign stop = (cd_i == '0) && !bypass_i;
  assign per  = {1'b0, cd_i} + PER_W'(stretch_q);
  assign sum  = {1'b0, acc_q} + {1'b0, fp_i};

  assign term_o = tick_i && !stop &&
                  (bypass_i || ({1'b0, cnt_q} + PER_W'(1) >= per));

  always_comb begin
    if (stop || bypass_i || term_o) cnt_next_o = '0;
    else if (tick_i)                cnt_next_o = cnt_q + 1'b1;
    else                            cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next_o;
      if (!frac_en_i) begin
        acc_q     <= '0;
        stretch_q <= 1'b0;
      end else if (term_o) begin
        acc_q     <= sum[FP_W-1:0];
        stretch_q <= sum[FP_W];
      end
    end
  end

  // R6
  no_stretch_small_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(frac_en_i)) |-> !stretch_q);
  // R2
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> (cnt_q == '0));
endmodule

// File: rtl/baud_sck_out.sv
module baud_sck_out #(
  parameter int CD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            ext_i,
  input  logic            fix_i,
  input  logic            ext_lvl_i,
  input  logic [CD_W-1:0] cd_i,
  input  logic [CD_W-1:0] cnt_next_i,
  output logic            sck_o
);
  logic [CD_W-1:0] half;
  logic            sck_q;
  logic            ext_q;
  logic            neg_q;

  assign half = cd_i >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      sck_q <= en_i && (ext_i ? ext_lvl_i : (cnt_next_i < half));
      // half-cycle extension for odd divisors on the system clock
      ext_q <= en_i && !ext_i && fix_i && (half != '0) && (cnt_next_i == half);
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= ext_q;
  end

  assign sck_o = sck_q | (ext_q & ~neg_q);

  // R11
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en_i)) |-> !(sck_q || ext_q));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int CD_W      = 16,
  parameter int FP_W      = 3,
  parameter int PRESC_DIV = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_sck_i,
  input  logic [1:0]      src_sel_i,
  input  logic            sync_mode_i,
  input  logic            over_i,
  input  logic [CD_W-1:0] cd_i,
  input  logic [FP_W-1:0] fp_i,
  output logic            baud_en_o,
  output logic            samp_en_o,
  output logic            sck_o
);
  localparam int OVR_W = 4;
  localparam logic [OVR_W-1:0] LAST16 = OVR_W'(15);
  localparam logic [OVR_W-1:0] LAST8  = OVR_W'(7);

  logic tick, ext_lvl, term;
  logic [CD_W-1:0] cnt_next;
  logic is_ext, is_sys, bypass, frac_en, sck_en;
  logic [OVR_W-1:0] ovr_q, last;
  logic samp_q, baud_q;

  assign is_ext  = (src_e'(src_sel_i) == SRC_EXT);
  assign is_sys  = (src_e'(src_sel_i) == SRC_SYS);
  assign bypass  = sync_mode_i && is_ext;
  assign frac_en = !sync_mode_i && (cd_i > CD_W'(1));
  assign sck_en  = sync_mode_i && (src_e'(src_sel_i) != SRC_RSV);
  assign last    = over_i ? LAST8 : LAST16;

  baud_src_sel #(.PRESC_DIV(PRESC_DIV)) u_src (
    .clk_i, .rst_ni, .ext_sck_i, .src_sel_i,
    .tick_o(tick), .ext_lvl_o(ext_lvl)
  );

  baud_frac_div #(.CD_W(CD_W), .FP_W(FP_W)) u_div (
    .clk_i, .rst_ni, .tick_i(tick), .bypass_i(bypass), .frac_en_i(frac_en),
    .cd_i, .fp_i, .term_o(term), .cnt_next_o(cnt_next)
  );

  baud_sck_out #(.CD_W(CD_W)) u_sck (
    .clk_i, .rst_ni, .en_i(sck_en), .ext_i(is_ext), .fix_i(is_sys && cd_i[0]),
    .ext_lvl_i(ext_lvl), .cd_i, .cnt_next_i(cnt_next), .sck_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= '0;
      samp_q <= 1'b0;
      baud_q <= 1'b0;
    end else begin
      samp_q <= term;
      baud_q <= term && (sync_mode_i || ovr_q >= last);
      if (term && !sync_mode_i) ovr_q <= (ovr_q >= last) ? '0 : ovr_q + 1'b1;
    end
  end

  assign samp_en_o = samp_q;
  assign baud_en_o = baud_q;

  // R5
  baud_on_samp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_en_o |-> samp_en_o);
  // R8
  rsv_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(src_sel_i) == 2'd2) |-> !samp_en_o);
  // R12
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !(baud_en_o || samp_en_o || sck_o));
endmodule

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;
  localparam int EXT_HALF = 5;

  logic clk = 1'b0, rst_ni = 1'b0, ext_sck = 1'b0;
  logic [1:0] src_sel = '0;
  logic sync_mode = 1'b0, over = 1'b0;
  logic [15:0] cd = 16'd1;
  logic [2:0] fp = '0;
  logic baud_en, samp_en, sck;

  int n_chk = 0, n_err = 0;
  int samp_n = 0, baud_n = 0, hi_n = 0;
  bit meas = 1'b0, done = 1'b0;
  int ext_cnt = 0;

  always #10 clk = ~clk;

  frac_baud_gen u_dut (
    .clk_i(clk), .rst_ni, .ext_sck_i(ext_sck), .src_sel_i(src_sel),
    .sync_mode_i(sync_mode), .over_i(over), .cd_i(cd), .fp_i(fp),
    .baud_en_o(baud_en), .samp_en_o(samp_en), .sck_o(sck)
  );

  always @(negedge clk) begin
    ext_cnt <= (ext_cnt == EXT_HALF - 1) ? 0 : ext_cnt + 1;
    if (ext_cnt == EXT_HALF - 1) ext_sck <= ~ext_sck;
    if (meas) begin
      if (samp_en) samp_n++;
      if (baud_en) baud_n++;
    end
  end
  always @(posedge clk) begin #5; if (meas && sck) hi_n++; end
  always @(negedge clk) begin #5; if (meas && sck) hi_n++; end

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic run_case(int s, bit sy, bit ov, int c, int f);
    int t, per, w, e_samp, e_baud, e_hi;
    string rs, rb, rk;
    src_sel = 2'(s); sync_mode = sy; over = ov; cd = 16'(c); fp = 3'(f);
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #7;
    // R12: outputs quiet in reset
    chk("R12", "reset outputs", int'({baud_en, samp_en, sck}), 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    t = (s == 0) ? 1 : (s == 1) ? 8 : 2 * EXT_HALF;
    if (s == 2 || (c == 0 && !(sy && s == 3))) begin
      w = 200; e_samp = 0; e_baud = 0; e_hi = 0;
      rs = (s == 2) ? "R8" : "R7"; rb = rs; rk = rs;
    end else if (sy) begin
      per = (s == 3) ? 1 : c;
      w = t * per * 8; e_samp = 8; e_baud = 8;
      if (s == 0)      begin e_hi = (c >= 2) ? 8 * c : 0; rs = "R2"; rk = "R9"; end
      else if (s == 1) begin e_hi = 8 * 2 * t * (c / 2); rs = "R1"; rk = "R10"; end
      else             begin e_hi = 8 * 2 * EXT_HALF; rs = "R3"; rk = "R3"; end
      rb = rs;
    end else begin
      per = (c == 1) ? 8 : 8 * c + f;
      w = t * per * 2; e_samp = 16; e_baud = ov ? 2 : 1; e_hi = 0;
      rs = (c == 1) ? "R6" : "R4"; rb = "R5"; rk = "R11";
    end
    repeat (w + 40) @(posedge clk);
    #1 begin samp_n = 0; baud_n = 0; hi_n = 0; meas = 1'b1; end
    repeat (w) @(posedge clk);
    #1 meas = 1'b0;
    chk(rs, $sformatf("samp src%0d sync%0d cd%0d fp%0d", s, sy, c, f), samp_n, e_samp);
    chk(rb, $sformatf("baud src%0d sync%0d over%0d cd%0d", s, sy, ov, c), baud_n, e_baud);
    chk(rk, $sformatf("sck halves src%0d sync%0d cd%0d", s, sy, c), hi_n, e_hi);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    run_case(0, 1, 0, 5, 0);   // R9 odd divisor, balanced
    run_case(0, 1, 0, 6, 0);   // R2 even divisor
    run_case(1, 1, 0, 5, 0);   // R10 odd divisor, unbalanced
    run_case(3, 1, 0, 0, 0);   // R3 divisor ignored
    run_case(3, 1, 0, 9, 2);   // R3
    run_case(0, 0, 0, 1, 5);   // R6 fraction bypassed
    run_case(0, 0, 0, 4, 3);   // R4 / R5 x16
    run_case(0, 0, 1, 4, 7);   // R5 x8
    run_case(1, 0, 1, 3, 1);   // R1 prescaled async
    run_case(3, 0, 0, 2, 6);   // R1 pin async
    run_case(2, 1, 0, 4, 0);   // R8 reserved
    run_case(0, 0, 0, 0, 3);   // R7 stopped
    run_case(0, 1, 0, 0, 0);   // R7 stopped sync
    for (int i = 0; i < 16; i++) begin
      int s = $urandom_range(0, 3);
      if (s == 2 && $urandom_range(0, 2) != 0) s = 0;
      run_case(s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               $urandom_range(0, 10), $urandom_range(0, 7));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule